// File: doc/BRIEF.md
# Memory Access Watchpoint Unit

This block watches the stream of memory accesses that leave an arbiter and flags those that fall inside programmed windows. It holds four independent watchpoints. Each one filters on three things: an inclusive address window, a mask of operation kinds and a mask of requesting clients. When an access passes all three filters on a watchpoint that is armed, that watchpoint freezes a record of the access and raises its status bit. A global enable mask selects which status bits drive the single interrupt line. A priority field names the lowest-numbered pending source, so a service routine knows which one to handle first.

Software programs and services the unit through a simple strobe port with separate write and read strobes. Clearing an event takes two writes. A write to the watchpoint's own acknowledge register re-arms capture. A write-one-to-clear to the global acknowledge register drops the status bit. The reset input is asynchronous and active low, and it is released synchronously inside the block through two flops.

Top module: `mem_watch_unit`

## Requirements
- R1: After reset, every window bound, operation mask, client mask, global mask, status bit and capture register reads as zero, and `irq` is low.
- R2: An access matches a watchpoint when `acc_valid` is high, the first bound is less than or equal to `acc_addr`, `acc_addr` is less than or equal to the last bound, the access's operation bit is set in the operation mask, and bit `acc_client` of the client mask is set.
- R3: Operations are one-hot in `acc_op` and in the operation mask, with bit 0 for read and bit 1 for write.
- R4: The first match on an armed watchpoint stores the address, the operation, the client index and the size. A later match does not change these values until the watchpoint is acknowledged. The info word holds the operation at bit 0 and up, the first client at bit 8 and up, and the size at bit 16 and up.
- R5: The captured-clients register is the OR of the one-hot client codes of all matching accesses since the last re-arm.
- R6: A capture sets that watchpoint's status bit. A match on a watchpoint that is still holding a capture sets nothing.
- R7: Writing ones to the global acknowledge register clears the matching status bits. The capture stays frozen after this write.
- R8: Any write to a watchpoint's acknowledge register re-arms it and clears its captured clients, but leaves its status bit alone. A match in the same cycle as that write is ignored.
- R9: If a capture and a global acknowledge of the same bit happen in the same cycle, the status bit ends up set.
- R10: `irq` is high exactly when some status bit is set with its global mask bit also set. The masked-status register shows these bits in its low bits.
- R11: In the masked-status register, bit 31 is set when any source is pending, and bits 17:16 give the lowest-numbered pending index.
- R12: Watchpoint k uses word addresses 8k+0 (first bound), 8k+1 (last bound), 8k+2 (operation mask), 8k+3 (client mask), 8k+4 (captured clients), 8k+5 (captured address), 8k+6 (info) and 8k+7 (acknowledge). The global registers are 0x20 (mask), 0x21 (raw status), 0x22 (masked status) and 0x23 (acknowledge). Read data appears on the clock edge that samples `reg_rd`.
- R13: An access with `acc_valid` low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Monitored access present |
| acc_addr | input | ADDR_W | Access address |
| acc_op | input | OP_W | One-hot operation (bit 0 read, bit 1 write) |
| acc_client | input | CLI_W | Requesting client index |
| acc_size | input | SIZE_W | Access size |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | RA_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Combined masked interrupt |

## Verification
An access that is present at a clock edge updates the status, the capture registers and `irq` on that same edge. A configuration write takes effect for accesses from the following cycle onward. A read strobe loads `reg_rdata` on the edge that samples it. The bench drives every stimulus on a falling edge and holds it for one full cycle. It then samples `irq` at the next falling edge. Register contents are checked through a separate read that starts on a later falling edge, so every comparison falls half a cycle after the edge that produced the value.

// File: rtl/mwu_pkg.sv
package mwu_pkg;

  localparam int OP_RD = 0;
  localparam int OP_WR = 1;

  typedef enum logic [2:0] {
    REG_FIRST = 3'd0,
    REG_LAST  = 3'd1,
    REG_OPM   = 3'd2,
    REG_CLM   = 3'd3,
    REG_CCLI  = 3'd4,
    REG_CADDR = 3'd5,
    REG_CINFO = 3'd6,
    REG_ACK   = 3'd7
  } wp_reg_e;

  localparam int WP_STRIDE = 8;

  localparam logic [1:0] GLB_MASK = 2'd0;
  localparam logic [1:0] GLB_RAW  = 2'd1;
  localparam logic [1:0] GLB_MSK  = 2'd2;
  localparam logic [1:0] GLB_GACK = 2'd3;

  localparam int INFO_OP_LSB    = 0;
  localparam int INFO_FIRST_LSB = 8;
  localparam int INFO_SIZE_LSB  = 16;

  localparam int PRI_IDX_LSB = 16;
  localparam int PRI_VLD_BIT = 31;

endpackage

// File: rtl/mwu_match.sv
module mwu_match #(
  parameter int ADDR_W   = 32,
  parameter int N_CLIENT = 16,
  parameter int OP_W     = 2,
  localparam int CLI_W   = $clog2(N_CLIENT)
) (
  input  logic [ADDR_W-1:0]   lo_bound,
  input  logic [ADDR_W-1:0]   hi_bound,
  input  logic [OP_W-1:0]     op_mask,
  input  logic [N_CLIENT-1:0] cli_mask,
  input  logic                acc_valid,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [OP_W-1:0]     acc_op,
  input  logic [CLI_W-1:0]    acc_client,
  output logic                hit
);

  logic in_window;
  logic op_ok;
  logic cli_ok;

  always_comb begin
    in_window = (acc_addr >= lo_bound) && (acc_addr <= hi_bound);
    op_ok     = |(acc_op & op_mask);
    cli_ok    = cli_mask[acc_client];
    hit       = acc_valid && in_window && op_ok && cli_ok;
  end

endmodule

// File: rtl/mwu_wp_unit.sv
module mwu_wp_unit
  import mwu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int N_CLIENT = 16,
  parameter int OP_W     = 2,
  parameter int SIZE_W   = 4,
  parameter int DATA_W   = 32,
  localparam int CLI_W   = $clog2(N_CLIENT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  wp_reg_e             reg_sel,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                acc_valid,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [OP_W-1:0]     acc_op,
  input  logic [CLI_W-1:0]    acc_client,
  input  logic [SIZE_W-1:0]   acc_size,
  output logic [DATA_W-1:0]   rd_word,
  output logic                cap_evt
);

  logic [ADDR_W-1:0]   lo_q, hi_q;
  logic [OP_W-1:0]     opm_q;
  logic [N_CLIENT-1:0] clm_q;
  logic                locked_q;
  logic [N_CLIENT-1:0] ccli_q;
  logic [ADDR_W-1:0]   caddr_q;
  logic [OP_W-1:0]     cop_q;
  logic [CLI_W-1:0]    cfirst_q;
  logic [SIZE_W-1:0]   csize_q;

  logic                hit;
  logic                ack;
  logic                lo_en, hi_en, opm_en, clm_en;
  logic                lock_en, locked_d;
  logic                ccli_en;
  logic [N_CLIENT-1:0] ccli_d;
  logic [N_CLIENT-1:0] cli_onehot;

  mwu_match #(
    .ADDR_W  (ADDR_W),
    .N_CLIENT(N_CLIENT),
    .OP_W    (OP_W)
  ) i_match (
    .lo_bound  (lo_q),
    .hi_bound  (hi_q),
    .op_mask   (opm_q),
    .cli_mask  (clm_q),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .acc_op    (acc_op),
    .acc_client(acc_client),
    .hit       (hit)
  );

  // next-state logic
  always_comb begin
    ack        = cfg_we && (reg_sel == REG_ACK);
    lo_en      = cfg_we && (reg_sel == REG_FIRST);
    hi_en      = cfg_we && (reg_sel == REG_LAST);
    opm_en     = cfg_we && (reg_sel == REG_OPM);
    clm_en     = cfg_we && (reg_sel == REG_CLM);
    cli_onehot = N_CLIENT'(1) << acc_client;
    cap_evt    = hit && !locked_q && !ack;
    lock_en    = cap_evt || ack;
    locked_d   = cap_evt;
    ccli_en    = ack || (hit && !ack);
    if (ack)
      ccli_d = '0;
    else if (locked_q)
      ccli_d = ccli_q | cli_onehot;
    else
      ccli_d = cli_onehot;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q     <= '0;
      hi_q     <= '0;
      opm_q    <= '0;
      clm_q    <= '0;
      locked_q <= 1'b0;
      ccli_q   <= '0;
      caddr_q  <= '0;
      cop_q    <= '0;
      cfirst_q <= '0;
      csize_q  <= '0;
    end else begin
      if (lo_en)   lo_q     <= wdata[ADDR_W-1:0];
      if (hi_en)   hi_q     <= wdata[ADDR_W-1:0];
      if (opm_en)  opm_q    <= wdata[OP_W-1:0];
      if (clm_en)  clm_q    <= wdata[N_CLIENT-1:0];
      if (lock_en) locked_q <= locked_d;
      if (ccli_en) ccli_q   <= ccli_d;
      if (cap_evt) begin
        caddr_q  <= acc_addr;
        cop_q    <= acc_op;
        cfirst_q <= acc_client;
        csize_q  <= acc_size;
      end
    end
  end

  // read-back mux
  always_comb begin
    rd_word = '0;
    case (reg_sel)
      REG_FIRST: rd_word = DATA_W'(lo_q);
      REG_LAST:  rd_word = DATA_W'(hi_q);
      REG_OPM:   rd_word = DATA_W'(opm_q);
      REG_CLM:   rd_word = DATA_W'(clm_q);
      REG_CCLI:  rd_word = DATA_W'(ccli_q);
      REG_CADDR: rd_word = DATA_W'(caddr_q);
      REG_CINFO: begin
        rd_word[INFO_OP_LSB    +: OP_W]   = cop_q;
        rd_word[INFO_FIRST_LSB +: CLI_W]  = cfirst_q;
        rd_word[INFO_SIZE_LSB  +: SIZE_W] = csize_q;
      end
      default:   rd_word = '0;
    endcase
  end

  // R4: a held capture does not move while no acknowledge arrives
  p_capture_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !ack) |=> ($stable(caddr_q) && $stable(cfirst_q) && $stable(csize_q)));

  // R8: acknowledge always leaves the unit re-armed
  p_ack_rearms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !locked_q);

  // R5: accumulated clients keep all earlier bits while held
  p_clients_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !ack) |=> ((ccli_q & $past(ccli_q)) == $past(ccli_q)));

endmodule

// File: rtl/mwu_irq_ctrl.sv
module mwu_irq_ctrl #(
  parameter int NUM_WP = 4,
  localparam int IDX_W = (NUM_WP > 1) ? $clog2(NUM_WP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_WP-1:0] cap_evt,
  input  logic              mask_we,
  input  logic              gack_we,
  input  logic [NUM_WP-1:0] wbits,
  output logic [NUM_WP-1:0] raw_q,
  output logic [NUM_WP-1:0] mask_q,
  output logic [NUM_WP-1:0] masked,
  output logic [IDX_W-1:0]  pri_idx,
  output logic              pri_vld,
  output logic              irq
);

  logic              st_en;
  logic [NUM_WP-1:0] st_d;
  logic [NUM_WP-1:0] clr_bits;

  // next-state logic: a new capture beats a same-cycle clear
  always_comb begin
    clr_bits = gack_we ? wbits : '0;
    st_en    = gack_we || (|cap_evt);
    st_d     = (raw_q & ~clr_bits) | cap_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      if (st_en)   raw_q  <= st_d;
      if (mask_we) mask_q <= wbits;
    end
  end

  // masking and fixed-priority selection, lowest index first
  always_comb begin
    masked  = raw_q & mask_q;
    irq     = |masked;
    pri_vld = 1'b0;
    pri_idx = '0;
    for (int k = NUM_WP - 1; k >= 0; k--) begin
      if (masked[k]) begin
        pri_vld = 1'b1;
        pri_idx = IDX_W'(k);
      end
    end
  end

  for (genvar g = 0; g < NUM_WP; g++) begin : g_st_chk
    // R6: a capture always leaves its status bit set
    p_status_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[g] |=> raw_q[g]);
    // R7: global acknowledge without a capture clears the bit
    p_status_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (gack_we && wbits[g] && !cap_evt[g]) |=> !raw_q[g]);
  end

  // R11: selected index is pending and nothing lower is pending
  p_priority_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pri_vld |-> (masked[pri_idx] &&
                 ((masked & ((NUM_WP'(1) << pri_idx) - NUM_WP'(1))) == '0)));

endmodule

// File: rtl/mem_watch_unit.sv
module mem_watch_unit
  import mwu_pkg::*;
#(
  parameter int NUM_WP   = 4,
  parameter int ADDR_W   = 32,
  parameter int N_CLIENT = 16,
  parameter int OP_W     = 2,
  parameter int SIZE_W   = 4,
  parameter int DATA_W   = 32,
  localparam int CLI_W   = $clog2(N_CLIENT),
  localparam int GLB_BASE = NUM_WP * WP_STRIDE,
  localparam int RA_W    = $clog2(GLB_BASE + 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [OP_W-1:0]   acc_op,
  input  logic [CLI_W-1:0]  acc_client,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);

  localparam int IDX_W = (NUM_WP > 1) ? $clog2(NUM_WP) : 1;
  localparam int WI_W  = RA_W - 3;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // address decode
  logic [WI_W-1:0]   wp_idx;
  wp_reg_e           wp_off;
  logic              is_glb;
  logic [1:0]        glb_off;
  logic              mask_we, gack_we;

  always_comb begin
    wp_idx  = reg_addr[RA_W-1:3];
    wp_off  = wp_reg_e'(reg_addr[2:0]);
    is_glb  = (reg_addr[RA_W-1:2] == (RA_W-2)'(GLB_BASE / 4));
    glb_off = reg_addr[1:0];
    mask_we = reg_wr && is_glb && (glb_off == GLB_MASK);
    gack_we = reg_wr && is_glb && (glb_off == GLB_GACK);
  end

  logic [NUM_WP-1:0] cap_evt;
  logic [DATA_W-1:0] wp_rd [NUM_WP];
  logic [NUM_WP-1:0] raw_st, mask_st, masked_st;
  logic [IDX_W-1:0]  pri_idx;
  logic              pri_vld;

  for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
    logic sel;
    assign sel = (wp_idx == WI_W'(g));

    mwu_wp_unit #(
      .ADDR_W  (ADDR_W),
      .N_CLIENT(N_CLIENT),
      .OP_W    (OP_W),
      .SIZE_W  (SIZE_W),
      .DATA_W  (DATA_W)
    ) i_wp (
      .clk       (clk),
      .rst_n     (rst_ni),
      .cfg_we    (reg_wr && sel),
      .reg_sel   (wp_off),
      .wdata     (reg_wdata),
      .acc_valid (acc_valid),
      .acc_addr  (acc_addr),
      .acc_op    (acc_op),
      .acc_client(acc_client),
      .acc_size  (acc_size),
      .rd_word   (wp_rd[g]),
      .cap_evt   (cap_evt[g])
    );
  end

  mwu_irq_ctrl #(
    .NUM_WP(NUM_WP)
  ) i_irq (
    .clk    (clk),
    .rst_n  (rst_ni),
    .cap_evt(cap_evt),
    .mask_we(mask_we),
    .gack_we(gack_we),
    .wbits  (reg_wdata[NUM_WP-1:0]),
    .raw_q  (raw_st),
    .mask_q (mask_st),
    .masked (masked_st),
    .pri_idx(pri_idx),
    .pri_vld(pri_vld),
    .irq    (irq)
  );

  // read mux and registered read data
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    rd_val = '0;
    if (is_glb) begin
      case (glb_off)
        GLB_MASK: rd_val = DATA_W'(mask_st);
        GLB_RAW:  rd_val = DATA_W'(raw_st);
        GLB_MSK: begin
          rd_val[NUM_WP-1:0]               = masked_st;
          rd_val[PRI_IDX_LSB +: IDX_W]     = pri_idx;
          rd_val[PRI_VLD_BIT]              = pri_vld;
        end
        default:  rd_val = '0;
      endcase
    end else begin
      for (int k = 0; k < NUM_WP; k++) begin
        if (wp_idx == WI_W'(k)) rd_val = wp_rd[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_val;
  end

  assign reg_rdata = rdata_q;

  // R13: an idle access cycle raises no status bit
  p_idle_no_status_r13: assert property (@(posedge clk) disable iff (!rst_ni)
    !acc_valid |=> ((raw_st & ~$past(raw_st)) == '0));

  // R12: read data only changes on a read strobe
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    !reg_rd |=> $stable(reg_rdata));

endmodule

// File: tb/test_mem_watch_unit.sv
module test_mem_watch_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic [1:0]  acc_op;
  logic [3:0]  acc_client;
  logic [3:0]  acc_size;
  logic        reg_wr, reg_rd;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mem_watch_unit i_mem_watch_unit (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_op(acc_op),
    .acc_client(acc_client), .acc_size(acc_size),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  localparam logic [1:0] RD = 2'b01;
  localparam logic [1:0] WR = 2'b10;
  localparam logic [5:0] A_MASK = 6'h20;
  localparam logic [5:0] A_RAW  = 6'h21;
  localparam logic [5:0] A_MSK  = 6'h22;
  localparam logic [5:0] A_GACK = 6'h23;

  // {addr, op, client, expected raw status, size}
  localparam logic [47:0] VEC [12] = '{
    {32'h0000_1000, 4'd2, 4'd1, 4'h1, 4'd0},
    {32'h0000_10FF, 4'd2, 4'd1, 4'h1, 4'd0},
    {32'h0000_1100, 4'd2, 4'd1, 4'h0, 4'd0},
    {32'h0000_0FFF, 4'd2, 4'd1, 4'h0, 4'd0},
    {32'h0000_1000, 4'd1, 4'd1, 4'h0, 4'd0},
    {32'h0000_10A0, 4'd1, 4'd3, 4'h4, 4'd0},
    {32'h0000_2000, 4'd1, 4'd5, 4'h6, 4'd0},
    {32'h0000_2010, 4'd2, 4'd9, 4'h2, 4'd0},
    {32'h0000_3000, 4'd2, 4'd7, 4'h8, 4'd0},
    {32'h0000_3000, 4'd2, 4'd6, 4'h0, 4'd0},
    {32'h0000_1050, 4'd2, 4'd2, 4'h0, 4'd0},
    {32'h0000_2FFF, 4'd1, 4'd0, 4'h2, 4'd0}
  };

  function automatic logic [5:0] wa(input int wp, input int off);
    return 6'(wp * 8 + off);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] op,
                        input logic [3:0] cl, input logic [3:0] sz);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_op = op; acc_client = cl; acc_size = sz;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic clear_all();
    for (int k = 0; k < 4; k++) wr(wa(k, 7), 32'h0);
    wr(A_GACK, 32'hF);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; acc_valid = 0; acc_addr = 0; acc_op = 0; acc_client = 0;
    acc_size = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(wa(0, 0), v); chk("R1 first", v, 0);
    rd(wa(1, 3), v); chk("R1 clm", v, 0);
    rd(wa(2, 5), v); chk("R1 caddr", v, 0);
    rd(A_MASK, v);   chk("R1 mask", v, 0);
    rd(A_RAW, v);    chk("R1 raw", v, 0);
    access(32'h0, WR, 4'd0, 4'd1);
    rd(A_RAW, v);    chk("R1 no hit with zero masks", v, 0);

    // configuration
    wr(wa(0,0), 32'h1000); wr(wa(0,1), 32'h10FF); wr(wa(0,2), 32'h2); wr(wa(0,3), 32'h0002);
    wr(wa(1,0), 32'h2000); wr(wa(1,1), 32'h2FFF); wr(wa(1,2), 32'h3); wr(wa(1,3), 32'hFFFF);
    wr(wa(2,0), 32'h1080); wr(wa(2,1), 32'h2010); wr(wa(2,2), 32'h1); wr(wa(2,3), 32'h0028);
    wr(wa(3,0), 32'h3000); wr(wa(3,1), 32'h3000); wr(wa(3,2), 32'h3); wr(wa(3,3), 32'h0080);
    wr(A_MASK, 32'h7);

    // R12 register read-back
    rd(wa(2,0), v); chk("R12 first", v, 32'h1080);
    rd(wa(2,1), v); chk("R12 last", v, 32'h2010);
    rd(wa(2,2), v); chk("R12 opm", v, 32'h1);
    rd(wa(2,3), v); chk("R12 clm", v, 32'h28);
    rd(A_MASK, v);  chk("R12 mask", v, 32'h7);

    // R2 R3 R10 match table
    foreach (VEC[i]) begin
      access(VEC[i][47:16], VEC[i][13:12], VEC[i][11:8], VEC[i][3:0]);
      chk("R10 irq vec", {31'b0, irq}, {31'b0, |(VEC[i][7:4] & 4'h7)});
      rd(A_RAW, v); chk("R2 R3 raw vec", v, {28'b0, VEC[i][7:4]});
      rd(A_MSK, v); chk("R10 masked vec", {28'b0, v[3:0]}, {28'b0, VEC[i][7:4] & 4'h7});
      clear_all();
    end

    // R4 R5 capture
    wr(wa(0,3), 32'h0006);
    access(32'h1010, WR, 4'd1, 4'd5);
    access(32'h1020, WR, 4'd2, 4'd3);
    rd(wa(0,4), v); chk("R5 clients", v, 32'h6);
    rd(wa(0,5), v); chk("R4 addr", v, 32'h1010);
    rd(wa(0,6), v); chk("R4 info", v, 32'h0005_0102);
    // R7 global ack keeps capture frozen; R6 no re-raise while held
    wr(A_GACK, 32'h1);
    rd(A_RAW, v); chk("R7 status cleared", v, 0);
    access(32'h1030, WR, 4'd1, 4'd1);
    rd(A_RAW, v); chk("R6 no re-raise", v, 0);
    rd(wa(0,5), v); chk("R7 capture held", v, 32'h1010);
    // R8 re-arm
    wr(wa(0,7), 32'h0);
    rd(wa(0,4), v); chk("R8 clients cleared", v, 0);
    access(32'h1040, WR, 4'd2, 4'd7);
    rd(A_RAW, v); chk("R8 rearmed status", v, 32'h1);
    rd(wa(0,5), v); chk("R8 new addr", v, 32'h1040);
    wr(wa(0,7), 32'h0);
    rd(A_RAW, v); chk("R8 status kept", v, 32'h1);
    chk("R8 irq kept", {31'b0, irq}, 32'h1);
    wr(A_GACK, 32'h1);
    // R8 hit in same cycle as instance ack is ignored
    @(negedge clk);
    reg_wr = 1; reg_addr = wa(0,7); reg_wdata = 0;
    acc_valid = 1; acc_addr = 32'h1050; acc_op = WR; acc_client = 4'd1; acc_size = 4'd2;
    @(negedge clk);
    reg_wr = 0; acc_valid = 0;
    rd(A_RAW, v); chk("R8 same-cycle hit ignored", v, 0);
    rd(wa(0,5), v); chk("R8 same-cycle addr", v, 32'h1040);
    // R9 capture beats global ack
    @(negedge clk);
    reg_wr = 1; reg_addr = A_GACK; reg_wdata = 32'hF;
    acc_valid = 1; acc_addr = 32'h1060; acc_op = WR; acc_client = 4'd1; acc_size = 4'd2;
    @(negedge clk);
    reg_wr = 0; acc_valid = 0;
    rd(A_RAW, v); chk("R9 set wins", v, 32'h1);
    rd(wa(0,5), v); chk("R9 addr", v, 32'h1060);

    // R11 priority
    clear_all();
    access(32'h2000, RD, 4'd5, 4'd0);
    rd(A_MSK, v); chk("R11 prio lowest", v, 32'h8001_0006);
    wr(A_MASK, 32'h5);
    rd(A_MSK, v); chk("R11 prio masked", v, 32'h8002_0004);
    chk("R10 irq masked on", {31'b0, irq}, 32'h1);
    wr(A_MASK, 32'h0);
    chk("R10 irq all masked", {31'b0, irq}, 32'h0);
    rd(A_MSK, v); chk("R11 none pending", v, 0);
    wr(A_MASK, 32'h7);

    // R13 invalid access ignored
    clear_all();
    @(negedge clk);
    acc_valid = 0; acc_addr = 32'h1010; acc_op = WR; acc_client = 4'd1;
    @(negedge clk);
    rd(A_RAW, v); chk("R13 idle", v, 0);
    rd(wa(0,4), v); chk("R13 clients untouched", v, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule